// File: doc/BRIEF.md
# Machine Interrupt Pending and Priority Unit

This block holds the machine-level interrupt enable and pending registers of a small RISC-V style core and decides which interrupt, if any, the core should take. Three sources exist. The timer source is a level derived each cycle from a 64-bit time value and a 64-bit compare value. The two event sources are sticky: one is set by any change of an external input level, and the other by a message-arrival strobe.

A global enable bit gates trap requests. Pending bits keep tracking their sources while the global enable is off. When a request is made, the block emits a one-cycle `trap_valid` together with a cause word. The block also keeps a waiting flag for a core halted until an interrupt arrives. An enabled event on either sticky source releases the halted core with a one-cycle `wake` pulse.

Top module: `irq_hub`

## Requirements
- R1: Only bit positions 7 (timer), 16 (input change) and 17 (message) exist in the enable and pending registers. Every other bit reads as zero, whatever value is written.
- R2: Pending bit 7 is 1 in the cycle after an edge at which the compare high word is below the time high word, or the high words are equal and the time low word is at least the compare low word. Otherwise it is 0. Software writes to the pending register never change bit 7.
- R3: Any change of `ext_in` (rising or falling) sampled at a clock edge sets pending bit 16 at that edge. The bit stays set until software clears it.
- R4: `msg_rx` high at a clock edge sets pending bit 17 at that edge. The bit stays set until software clears it.
- R5: A CSR write (`csr_we`=1) targets the enable register when `csr_sel`=0 and the pending register when `csr_sel`=1. `csr_op` 0 writes `csr_wdata`, 1 ORs it in, 2 clears the bits set in it, and 3 leaves the register unchanged. Software may clear pending bits 16 and 17 but can never set them.
- R6: If an event and a software clear of the same pending bit fall on the same edge, the bit ends up set.
- R7: Among the enabled pending bits, the first in the scan order 11, 3, 7, 9, 1, 5, 13, 16, 17 is chosen. Only 7, 16 and 17 can actually be pending, so bit 7 beats 16 and 16 beats 17. The cause is 0x80000000 plus the chosen index.
- R8: With the global enable (`gie_we`/`gie_wdata` register) clear, no trap is requested, but the pending bits still update.
- R9: `trap_valid` is high for exactly one cycle. It rises two edges after a CSR write while an enabled pending interrupt exists with the global enable set. It also rises one edge after the masked pending set turns from empty to non-empty. `trap_cause` is valid while `trap_valid` is high.
- R10: After `wfi_enter`, the block is waiting. An input change with enable bit 16 set, or a message with enable bit 17 set, raises `wake` for one cycle after that edge and ends waiting. Events while not waiting, or whose enable bit is clear, give no wake.
- R11: Reset clears enables, pending bits, the global enable, the waiting flag, `trap_valid` and `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 1 | 0 = enable register, 1 = pending register |
| csr_op | input | 2 | 0 write, 1 set bits, 2 clear bits, 3 none |
| csr_wdata | input | 32 | CSR write operand |
| csr_rdata | output | 32 | Selected register contents (combinational) |
| gie_we | input | 1 | Global enable write strobe |
| gie_wdata | input | 1 | New global enable value |
| wfi_enter | input | 1 | Core starts waiting for an interrupt |
| time_now | input | 64 | Current time count |
| time_cmp | input | 64 | Timer compare value |
| ext_in | input | 1 | External input level; any change is an event |
| msg_rx | input | 1 | Message-received strobe |
| trap_valid | output | 1 | One-cycle trap request |
| trap_cause | output | 32 | Cause code of the request |
| wake | output | 1 | One-cycle release of a waiting core |

## Verification
Two things can fall on the same clock edge: a software clear of a pending bit and the event that sets that same bit. The bench provokes this by raising `msg_rx` in the very cycle it issues a clear-bits write to pending bit 17. It then reads the pending register back and expects bit 17 still set. Priority is judged through a scoreboard: each trap the driver provokes pushes its predicted cause, and every `trap_valid` pulse must match the head of the queue.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   localparam int TMR_BIT  = 7;
   localparam int EXT_BIT  = 16;
   localparam int MSG_BIT  = 17;
   localparam int SCAN_LEN = 9;

   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_SET   = 2'd1,
      OP_CLEAR = 2'd2,
      OP_NONE  = 2'd3
   } csr_op_e;

   // fixed scan order, position 0 has the highest priority
   function automatic int scan_bit(input int pos);
      case (pos)
         0: scan_bit = 11;
         1: scan_bit = 3;
         2: scan_bit = 7;
         3: scan_bit = 9;
         4: scan_bit = 1;
         5: scan_bit = 5;
         6: scan_bit = 13;
         7: scan_bit = 16;
         default: scan_bit = 17;
      endcase
   endfunction

endpackage

// File: rtl/irq_timer_cmp.sv
module irq_timer_cmp #(
   parameter int TIME_W    = 64,
   parameter bit CMP_SPLIT = 1'b1
) (
   input  logic [TIME_W-1:0] time_now,
   input  logic [TIME_W-1:0] time_cmp,
   output logic              hit
);
   localparam int HALF_W = TIME_W / 2;

   if (TIME_W % 2 != 0) begin : g_bad_width
      $error("irq_timer_cmp: TIME_W must be even");
   end

   if (CMP_SPLIT) begin : g_split
      logic [HALF_W-1:0] t_hi, t_lo, c_hi, c_lo;
      assign t_hi = time_now[TIME_W-1:HALF_W];
      assign t_lo = time_now[HALF_W-1:0];
      assign c_hi = time_cmp[TIME_W-1:HALF_W];
      assign c_lo = time_cmp[HALF_W-1:0];
      assign hit  = ((c_hi == t_hi) && (t_lo >= c_lo)) || (c_hi < t_hi);
   end else begin : g_flat
      assign hit = (time_now >= time_cmp);
   end
endmodule

// File: rtl/irq_pend_regs.sv
module irq_pend_regs
   import irq_hub_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            csr_we,
   input  logic            csr_sel,
   input  logic [1:0]      csr_op,
   input  logic [XLEN-1:0] csr_wdata,
   input  logic            tmr_hit,
   input  logic            ext_in,
   input  logic            msg_rx,
   output logic [XLEN-1:0] en_q,
   output logic [XLEN-1:0] pend_q,
   output logic            ext_evt
);
   localparam logic [XLEN-1:0] IMPL_MASK =
      (XLEN'(1) << TMR_BIT) | (XLEN'(1) << EXT_BIT) | (XLEN'(1) << MSG_BIT);

   if (XLEN <= MSG_BIT) begin : g_bad_xlen
      $error("irq_pend_regs: XLEN too small for the event bits");
   end

   logic            ext_prev_q;
   logic [XLEN-1:0] en_new, pend_new;
   logic            wr_en, wr_pend;

   function automatic logic [XLEN-1:0] apply_op(input logic [XLEN-1:0] old,
                                                 input logic [XLEN-1:0] opnd,
                                                 input logic [1:0]      op);
      case (csr_op_e'(op))
         OP_WRITE: apply_op = opnd;
         OP_SET:   apply_op = old | opnd;
         OP_CLEAR: apply_op = old & ~opnd;
         default:  apply_op = old;
      endcase
   endfunction

   assign wr_en    = csr_we && !csr_sel;
   assign wr_pend  = csr_we &&  csr_sel;
   assign en_new   = apply_op(en_q, csr_wdata, csr_op);
   assign pend_new = apply_op(pend_q, csr_wdata, csr_op);
   assign ext_evt  = ext_in ^ ext_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ext_prev_q <= 1'b0;
      else        ext_prev_q <= ext_in;
   end

   for (genvar b = 0; b < XLEN; b++) begin : g_bit
      if (IMPL_MASK[b]) begin : g_impl
         always_ff @(posedge clk) begin
            if (!rst_n)     en_q[b] <= 1'b0;
            else if (wr_en) en_q[b] <= en_new[b];
         end
         if (b == TMR_BIT) begin : g_tmr
            always_ff @(posedge clk) begin
               if (!rst_n) pend_q[b] <= 1'b0;
               else        pend_q[b] <= tmr_hit;
            end
         end else begin : g_evt
            logic evt, keep;
            assign evt  = (b == EXT_BIT) ? ext_evt : msg_rx;
            assign keep = wr_pend ? pend_new[b] : 1'b1;
            always_ff @(posedge clk) begin
               if (!rst_n) pend_q[b] <= 1'b0;
               else        pend_q[b] <= evt | (pend_q[b] & keep);
            end
         end
      end else begin : g_tie
         assign en_q[b]   = 1'b0;
         assign pend_q[b] = 1'b0;
      end
   end

   p_unimpl_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_q | pend_q) & ~IMPL_MASK) == '0);
   p_timer_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pend_q[TMR_BIT] == $past(tmr_hit)));
   p_toggle_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_in != ext_prev_q) |=> pend_q[EXT_BIT]);
   p_msg_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      msg_rx |=> pend_q[MSG_BIT]);
   p_sw_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!msg_rx && !pend_q[MSG_BIT]) |=> !pend_q[MSG_BIT]);
   p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_rx && wr_pend && csr_op == OP_CLEAR) |=> pend_q[MSG_BIT]);
endmodule

// File: rtl/irq_select.sv
module irq_select
   import irq_hub_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IDX_W = $clog2(XLEN)
) (
   input  logic [XLEN-1:0]  eff,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   for (genvar p = 0; p < SCAN_LEN; p++) begin : g_chk
      if (scan_bit(p) >= XLEN) begin : g_bad
         $error("irq_select: scan entry beyond XLEN");
      end
   end

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int p = 0; p < SCAN_LEN; p++) begin
         if (!any && eff[scan_bit(p)]) begin
            any = 1'b1;
            idx = IDX_W'(scan_bit(p));
         end
      end
   end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int TIME_W    = 64,
   parameter bit CMP_SPLIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic              csr_sel,
   input  logic [1:0]        csr_op,
   input  logic [XLEN-1:0]   csr_wdata,
   output logic [XLEN-1:0]   csr_rdata,
   input  logic              gie_we,
   input  logic              gie_wdata,
   input  logic              wfi_enter,
   input  logic [TIME_W-1:0] time_now,
   input  logic [TIME_W-1:0] time_cmp,
   input  logic              ext_in,
   input  logic              msg_rx,
   output logic              trap_valid,
   output logic [XLEN-1:0]   trap_cause,
   output logic              wake
);
   localparam int IDX_W = $clog2(XLEN);

   if (XLEN < IDX_W + 1) begin : g_bad_cause
      $error("irq_hub: cause word too narrow");
   end

   logic              tmr_hit, ext_evt;
   logic [XLEN-1:0]   en_q, pend_q, eff;
   logic              gie_q, waiting_q, wake_q;
   logic              csr_wr_q, eff_any_q;
   logic              sel_any, trig, wake_d;
   logic [IDX_W-1:0]  sel_idx;
   logic              trap_valid_q;
   logic [XLEN-1:0]   trap_cause_q;

   irq_timer_cmp #(.TIME_W(TIME_W), .CMP_SPLIT(CMP_SPLIT)) i_cmp (
      .time_now (time_now),
      .time_cmp (time_cmp),
      .hit      (tmr_hit)
   );

   irq_pend_regs #(.XLEN(XLEN)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_we    (csr_we),
      .csr_sel   (csr_sel),
      .csr_op    (csr_op),
      .csr_wdata (csr_wdata),
      .tmr_hit   (tmr_hit),
      .ext_in    (ext_in),
      .msg_rx    (msg_rx),
      .en_q      (en_q),
      .pend_q    (pend_q),
      .ext_evt   (ext_evt)
   );

   assign eff = pend_q & en_q & {XLEN{gie_q}};

   irq_select #(.XLEN(XLEN), .IDX_W(IDX_W)) i_sel (
      .eff (eff),
      .any (sel_any),
      .idx (sel_idx)
   );

   assign csr_rdata = csr_sel ? pend_q : en_q;
   assign trig      = csr_wr_q || !eff_any_q;
   assign wake_d    = waiting_q && ((ext_evt && en_q[EXT_BIT]) ||
                                    (msg_rx  && en_q[MSG_BIT]));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gie_q        <= 1'b0;
         waiting_q    <= 1'b0;
         wake_q       <= 1'b0;
         csr_wr_q     <= 1'b0;
         eff_any_q    <= 1'b0;
         trap_valid_q <= 1'b0;
         trap_cause_q <= '0;
      end else begin
         if (gie_we) gie_q <= gie_wdata;
         wake_q    <= wake_d;
         if (wake_d)         waiting_q <= 1'b0;
         else if (wfi_enter) waiting_q <= 1'b1;
         csr_wr_q  <= csr_we;
         eff_any_q <= sel_any;
         trap_valid_q <= trig && sel_any && !trap_valid_q;
         if (trig && sel_any && !trap_valid_q)
            trap_cause_q <= {1'b1, (XLEN-1-IDX_W)'(0), sel_idx};
      end
   end

   assign trap_valid = trap_valid_q;
   assign trap_cause = trap_cause_q;
   assign wake       = wake_q;

   p_cause_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_q |-> trap_cause_q[XLEN-1]);
   p_no_trap_without_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_q |-> $past(gie_q));
   p_trap_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_q |=> !trap_valid_q);
   p_wake_needs_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_q |-> $past(waiting_q));
   p_wake_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_q |=> !wake_q);
endmodule

// File: tb/test_irq_hub.sv
module test_irq_hub;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0, csr_sel = 1'b0;
   logic [1:0]  csr_op = 2'd3;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        gie_we = 1'b0, gie_wdata = 1'b0, wfi_enter = 1'b0;
   logic [63:0] time_now = '0, time_cmp = '1;
   logic        ext_in = 1'b0, msg_rx = 1'b0;
   logic        trap_valid, wake;
   logic [31:0] trap_cause;

   int n_chk = 0, n_fail = 0;
   logic [31:0] exp_q[$];
   logic        prev_tv = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_hub i_irq_hub (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
      .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .gie_we(gie_we), .gie_wdata(gie_wdata), .wfi_enter(wfi_enter),
      .time_now(time_now), .time_cmp(time_cmp), .ext_in(ext_in),
      .msg_rx(msg_rx), .trap_valid(trap_valid), .trap_cause(trap_cause),
      .wake(wake)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: pops predicted causes as trap pulses appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (trap_valid) begin
            if (exp_q.size() == 0) chk("R8/R9 unexpected trap", trap_cause, 32'hx);
            else chk("R7 trap cause", trap_cause, exp_q.pop_front());
         end
         if (trap_valid && prev_tv) chk("R9 pulse width", 32'd2, 32'd1);
         prev_tv <= trap_valid;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic csr_wr(input logic sel, input logic [1:0] op, input logic [31:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_sel = sel; csr_op = op; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0; csr_op = 2'd3;
   endtask

   task automatic rd(input logic sel, input logic [31:0] exp, input string req);
      @(negedge clk);
      csr_sel = sel;
      #1 chk(req, csr_rdata, exp);
   endtask

   task automatic set_gie(input logic v);
      @(negedge clk);
      gie_we = 1'b1; gie_wdata = v;
      @(negedge clk);
      gie_we = 1'b0;
   endtask

   task automatic msg_pulse();
      @(negedge clk);
      msg_rx = 1'b1;
      @(negedge clk);
      msg_rx = 1'b0;
   endtask

   task automatic ext_flip();
      @(negedge clk);
      ext_in = ~ext_in;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R11 reset state
      rd(1'b0, 32'h0, "R11 enable after reset");
      rd(1'b1, 32'h0, "R11 pending after reset");
      chk("R11 trap_valid after reset", {31'b0, trap_valid}, 32'h0);
      chk("R11 wake after reset", {31'b0, wake}, 32'h0);

      // R1 only implemented bits
      csr_wr(1'b0, 2'd0, 32'hFFFF_FFFF);
      rd(1'b0, 32'h0003_0080, "R1 enable implemented bits");

      // R2 timer comparator (gie off, so R8: no trap expected)
      time_now = 64'h1_0000_0005; time_cmp = 64'h1_0000_0005;
      rd(1'b1, 32'h0000_0080, "R2 equal high, low equal");
      time_cmp = 64'h1_0000_0006;
      rd(1'b1, 32'h0, "R2 equal high, low below");
      time_cmp = 64'h0_FFFF_FFFF;
      rd(1'b1, 32'h0000_0080, "R2 compare high below");
      time_cmp = 64'h2_0000_0000;
      rd(1'b1, 32'h0, "R2 compare high above");
      csr_wr(1'b1, 2'd1, 32'hFFFF_FFFF);
      rd(1'b1, 32'h0, "R2/R5 software cannot set pending");
      time_cmp = '1;

      // R3 input change, both directions
      ext_flip();
      rd(1'b1, 32'h0001_0000, "R3 rising change");
      csr_wr(1'b1, 2'd2, 32'h0001_0000);
      rd(1'b1, 32'h0, "R5 clear bit 16");
      ext_flip();
      rd(1'b1, 32'h0001_0000, "R3 falling change");
      csr_wr(1'b1, 2'd0, 32'h0);
      rd(1'b1, 32'h0, "R5 write zero clears");

      // R4 message
      msg_pulse();
      rd(1'b1, 32'h0002_0000, "R4 message sets bit 17");
      csr_wr(1'b1, 2'd2, 32'h0002_0000);
      rd(1'b1, 32'h0, "R5 clear bit 17");

      // R6 event and clear on the same edge
      @(negedge clk);
      msg_rx = 1'b1; csr_we = 1'b1; csr_sel = 1'b1; csr_op = 2'd2; csr_wdata = 32'h0002_0000;
      @(negedge clk);
      msg_rx = 1'b0; csr_we = 1'b0; csr_op = 2'd3;
      rd(1'b1, 32'h0002_0000, "R6 event wins over clear");

      // R7/R9 priority and trap timing with gie on
      exp_q.push_back(32'h8000_0011);
      set_gie(1'b1);
      idle(4);
      chk("R9 queue drained after gie", exp_q.size(), 0);
      ext_flip();
      idle(3);
      chk("R9 no trap on added source without write", exp_q.size(), 0);
      exp_q.push_back(32'h8000_0010);
      csr_wr(1'b0, 2'd1, 32'h0);
      idle(4);
      time_cmp = 64'h5; time_now = 64'hA;
      idle(3);
      exp_q.push_back(32'h8000_0007);
      csr_wr(1'b0, 2'd1, 32'h0);
      idle(4);
      chk("R7 all predicted traps seen", exp_q.size(), 0);
      set_gie(1'b0);
      time_cmp = '1;

      // R8 gie off: pending updates, no trap
      csr_wr(1'b1, 2'd2, 32'hFFFF_FFFF);
      rd(1'b1, 32'h0, "R8 pending cleared");
      msg_pulse();
      idle(3);
      rd(1'b1, 32'h0002_0000, "R8 pending updates with gie off");
      csr_wr(1'b0, 2'd1, 32'h0);
      idle(3);

      // R10 wake
      @(negedge clk); wfi_enter = 1'b1;
      @(negedge clk); wfi_enter = 1'b0;
      msg_rx = 1'b1;
      @(negedge clk); msg_rx = 1'b0;
      chk("R10 wake on enabled message", {31'b0, wake}, 32'h1);
      @(negedge clk);
      chk("R10 wake is one cycle", {31'b0, wake}, 32'h0);
      msg_rx = 1'b1;
      @(negedge clk); msg_rx = 1'b0;
      chk("R10 no wake when not waiting", {31'b0, wake}, 32'h0);
      @(negedge clk); wfi_enter = 1'b1;
      @(negedge clk); wfi_enter = 1'b0;
      csr_wr(1'b0, 2'd2, 32'h0001_0000);
      @(negedge clk); ext_in = ~ext_in;
      @(negedge clk);
      chk("R10 no wake with enable 16 clear", {31'b0, wake}, 32'h0);
      msg_rx = 1'b1;
      @(negedge clk); msg_rx = 1'b0;
      chk("R10 wake on message while still waiting", {31'b0, wake}, 32'h1);
      idle(2);
      chk("R9 no unexpected traps pending", exp_q.size(), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule